// File: doc/BRIEF.md
# Handshaked Counter Snapshot Transfer

This block moves a consistent copy of a free-running binary counter from a source clock domain into a destination clock domain. The source runs near 50 MHz and the destination near 77 MHz. Sampling the counter bits directly in the destination could combine bits from two different counts. For example, a step from 0x7F to 0x80 flips every bit of an 8-bit value, so a direct sample can return a word that never existed.

The source side copies the counter into a holding register on every source cycle. To take a snapshot, destination logic raises a request. The request passes through a two-stage synchronizer into the source domain, where it stops the holding register from updating. That freeze indication is itself synchronized back through two destination flops, and one more destination register turns it into a valid flag. At that moment the destination loads the frozen word into its output register.

The requester holds the request until valid is seen and then drops it. Dropping the request releases the freeze, and valid returns low. A new request may start once valid is low again. Several clock cycles of latency are accepted in exchange for a word that is never torn. Both domains use synchronous active-high resets.

Top module: `snap_xfer_top`

## Requirements
- R1: After source reset the internal counter is 0 and it increments by one on every source clock, wrapping modulo 2^CNT_W.
- R2: While the synchronized request is low, the holding register takes the counter value of the previous source cycle.
- R3: The request reaches the source domain through two source flops, and while it is high the holding register keeps its value.
- R4: After `req_i` rises, `valid_o` stays low for at least 3 destination cycles and rises within 12 destination cycles.
- R5: When `valid_o` rises, `snap_o` is a whole counter word no earlier than the count at the moment the request rose and no later than the count at the moment valid is seen (modulo 2^CNT_W). This includes snapshots taken across the 0x7F to 0x80 step and across the wrap.
- R6: While `valid_o` stays high, `snap_o` does not change, however long the request is held.
- R7: After `req_i` falls, `valid_o` stays high for at least 2 destination cycles and falls within 12. A following request returns a fresh snapshot.
- R8: `valid_o` never rises while no request is pending.
- R9: Reset of both domains forces `valid_o` to 0 and `snap_o` to 0, also in the middle of a handshake. Afterwards the counter restarts from 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock (counter domain) |
| src_rst | input | 1 | Synchronous active-high reset, source domain |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst | input | 1 | Synchronous active-high reset, destination domain |
| req_i | input | 1 | Snapshot request, destination domain, four-phase |
| snap_o | output | CNT_W | Captured counter word, meaningful while valid_o is high |
| valid_o | output | 1 | Snapshot valid flag, destination domain |

## Verification
The assertions check on every cycle that the counter steps by one and that the holding register follows it while unfrozen and stays still while frozen. They also check that the output word equals the frozen holding register when valid rises, that it stays still while valid is high, and that valid does not rise without a request. Only the bench scenarios can show the latency bounds measured from the request edges and that each snapshot falls inside its request-to-valid window. The same scenarios cover snapshots taken across the 0x7F/0x80 step and the counter wrap, and the behaviour of a reset that arrives in the middle of a handshake.

// File: rtl/snap_pkg.sv
package snap_pkg;
  // Flop count of each synchronizer leg
  localparam int unsigned SYNC_DEPTH = 2;
  // Default counter width
  localparam int unsigned CNT_W_DEF  = 16;
endpackage

// File: rtl/snap_sync.sv
module snap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/snap_src_side.sv
module snap_src_side #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             freeze,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] hold
);
  // Free-running counter
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  // Holding register: follows the counter unless frozen
  always_ff @(posedge clk) begin
    if (rst)          hold <= '0;
    else if (!freeze) hold <= cnt;
  end
endmodule

// File: rtl/snap_dst_side.sv
module snap_dst_side #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack_s,
  input  logic [CNT_W-1:0] hold_i,
  output logic [CNT_W-1:0] snap_o,
  output logic             valid_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      snap_o  <= '0;
    end else begin
      valid_o <= ack_s;
      // Load once, on the rising edge of the returned freeze
      if (ack_s && !valid_o) snap_o <= hold_i;
    end
  end
endmodule

// File: rtl/snap_xfer_top.sv
module snap_xfer_top
  import snap_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic             src_clk,
  input  logic             src_rst,
  input  logic             dst_clk,
  input  logic             dst_rst,
  input  logic             req_i,
  output logic [CNT_W-1:0] snap_o,
  output logic             valid_o
);
  logic             freeze_w;
  logic             ack_w;
  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] hold_w;

  // Request leg into the source domain
  snap_sync #(.STAGES(SYNC_DEPTH)) u_req_sync (
    .clk(src_clk), .rst(src_rst), .d(req_i), .q(freeze_w)
  );

  snap_src_side #(.CNT_W(CNT_W)) u_src (
    .clk(src_clk), .rst(src_rst), .freeze(freeze_w),
    .cnt(cnt_w), .hold(hold_w)
  );

  // Acknowledge leg back into the destination domain
  snap_sync #(.STAGES(SYNC_DEPTH)) u_ack_sync (
    .clk(dst_clk), .rst(dst_rst), .d(freeze_w), .q(ack_w)
  );

  snap_dst_side #(.CNT_W(CNT_W)) u_dst (
    .clk(dst_clk), .rst(dst_rst), .ack_s(ack_w), .hold_i(hold_w),
    .snap_o(snap_o), .valid_o(valid_o)
  );
endmodule

// File: rtl/snap_xfer_chk.sv
module snap_xfer_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             src_clk,
  input logic             src_rst,
  input logic             dst_clk,
  input logic             dst_rst,
  input logic             req_i,
  input logic             valid_o,
  input logic [CNT_W-1:0] snap_o,
  input logic             freeze,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] hold
);
  // R1
  cnt_step_chk: assert property (@(posedge src_clk) disable iff (src_rst)
    1'b1 |=> cnt == CNT_W'($past(cnt) + 1'b1));

  // R2
  hold_track_chk: assert property (@(posedge src_clk) disable iff (src_rst)
    !freeze |=> hold == $past(cnt));

  // R3
  hold_frozen_chk: assert property (@(posedge src_clk) disable iff (src_rst)
    freeze && $past(freeze) |-> $stable(hold));

  // R5
  snap_whole_chk: assert property (@(posedge dst_clk) disable iff (dst_rst)
    $rose(valid_o) |-> snap_o == hold);

  // R6
  snap_stable_chk: assert property (@(posedge dst_clk) disable iff (dst_rst)
    valid_o && $past(valid_o) |-> $stable(snap_o));

  // R8
  no_spurious_valid_chk: assert property (@(posedge dst_clk) disable iff (dst_rst)
    !valid_o && !req_i |=> !valid_o);
endmodule

bind snap_xfer_top snap_xfer_chk #(.CNT_W(CNT_W)) u_chk (
  .src_clk(src_clk), .src_rst(src_rst), .dst_clk(dst_clk), .dst_rst(dst_rst),
  .req_i(req_i), .valid_o(valid_o), .snap_o(snap_o),
  .freeze(freeze_w), .cnt(cnt_w), .hold(hold_w)
);

// File: tb/sim_snap_xfer_top.sv
`timescale 1ns/1ps
module sim_snap_xfer_top;
  localparam int W = 8;
  localparam int MAXLAT = 12;
  // Stimulus and expectation rows: {idle cycles before request,
  // cycles to keep request after valid, expected valid level while kept}
  localparam int NVEC = 8;
  localparam int VEC [NVEC][3] = '{
    '{0, 0, 1}, '{1, 5, 1}, '{3, 2, 1}, '{7, 0, 1},
    '{2, 30, 1}, '{5, 1, 1}, '{0, 9, 1}, '{4, 3, 1}
  };

  logic src_clk = 0, dst_clk = 0;
  logic src_rst = 1, dst_rst = 1;
  logic req_i = 0;
  logic [W-1:0] snap_o;
  logic valid_o;

  int checks = 0, bad = 0;
  logic [W-1:0] bcnt;   // model of the free-running count

  always #10   src_clk = ~src_clk;  // 50 MHz
  always #6.5  dst_clk = ~dst_clk;  // ~77 MHz

  always @(posedge src_clk) begin
    if (src_rst) bcnt <= '0;
    else         bcnt <= bcnt + 1'b1;
  end

  snap_xfer_top #(.CNT_W(W)) u0 (
    .src_clk(src_clk), .src_rst(src_rst), .dst_clk(dst_clk), .dst_rst(dst_rst),
    .req_i(req_i), .snap_o(snap_o), .valid_o(valid_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic dwait(input int n);
    for (int i = 0; i < n; i++) @(negedge dst_clk);
  endtask

  // One four-phase handshake with window and latency checks
  task automatic sample(input int pre, input int keep, input int exp_v);
    logic [W-1:0] lo, hi, s0;
    int lat;
    dwait(pre);
    lo = bcnt;
    req_i = 1'b1;
    dwait(3);
    chk(valid_o == 1'b0, "R4 min rise latency", valid_o, 0);
    lat = 3;
    while (!valid_o && lat < MAXLAT) begin dwait(1); lat++; end
    chk(valid_o == 1'b1, "R4 max rise latency", lat, MAXLAT);
    hi = bcnt;
    chk(W'(snap_o - lo) <= W'(hi - lo), "R5 snapshot window", snap_o, hi);
    s0 = snap_o;
    for (int k = 0; k < keep; k++) begin
      dwait(1);
      chk(valid_o == exp_v[0] && snap_o == s0, "R6 held snapshot", snap_o, s0);
    end
    req_i = 1'b0;
    dwait(2);
    chk(valid_o == 1'b1, "R7 min fall latency", valid_o, 1);
    lat = 2;
    while (valid_o && lat < MAXLAT) begin dwait(1); lat++; end
    chk(valid_o == 1'b0, "R7 max fall latency", lat, MAXLAT);
  endtask

  initial begin
    logic [W-1:0] prev;
    // R9 reset state
    repeat (5) @(negedge src_clk);
    @(negedge dst_clk);
    chk(valid_o == 0, "R9 reset valid", valid_o, 0);
    chk(snap_o == 0, "R9 reset snap", snap_o, 0);
    @(negedge src_clk);
    src_rst = 0; dst_rst = 0;

    // R9, R1: first snapshot right after reset is near zero
    sample(0, 0, 1);

    // Table-driven handshakes (R4, R5, R6, R7)
    for (int v = 0; v < NVEC; v++) sample(VEC[v][0], VEC[v][1], VEC[v][2]);

    // R8: long idle, valid must stay low
    for (int i = 0; i < 40; i++) begin
      dwait(1);
      if (valid_o) break;
    end
    chk(valid_o == 0, "R8 idle valid", valid_o, 0);

    // R5, R1: many samples so snapshots straddle 0x7F/0x80 and the wrap
    for (int r = 0; r < 60; r++) sample(r % 5, r % 3, 1);

    // R6: request held long while counter passes through several values
    sample(1, 200, 1);

    // R7: back-to-back requests return fresh values
    req_i = 1; dwait(MAXLAT); prev = snap_o; req_i = 0; dwait(MAXLAT);
    dwait(20);
    req_i = 1; dwait(MAXLAT);
    chk(valid_o && snap_o != prev, "R7 fresh snapshot", snap_o, prev);
    // R9: reset in the middle of the handshake
    @(negedge src_clk);
    src_rst = 1; dst_rst = 1; req_i = 0;
    repeat (4) @(negedge src_clk);
    @(negedge dst_clk);
    chk(valid_o == 0, "R9 mid-handshake valid", valid_o, 0);
    chk(snap_o == 0, "R9 mid-handshake snap", snap_o, 0);
    @(negedge src_clk);
    src_rst = 0; dst_rst = 0;
    sample(0, 1, 1);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #2000000;
    checks++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule